// File: doc/BRIEF.md
# Clockless Bus I/O Port Slave

This block is an 8-bit I/O-port slave for a legacy expansion bus that provides no usable bus clock. The write strobe acts as the clock for a small capture stage. On its rising (release) edge, the stage latches the decoded port select and the write data, then flips a toggle flag. No address-latch-enable input exists: the address lines are decoded directly while a strobe is active.

A free-running local clock picks up the toggle through a two-flop synchronizer. It produces a one-cycle write pulse, together with the captured select and data, and stores the data in a small register file. Reads return the addressed register combinationally under an output enable, so the bus can sample the data before the read strobe rises.

The read strobe is also synchronized. When a qualifying read is released, a local read counter advances by one.

Top module: `isa_io_slave`

## Requirements
- R1: While `rst` is high and after its release, `rd_count` is 0, `wr_stb` is 0 and every port register reads 0.
- R2: A write hits the port when `bus_addr[9:2]` equals `BASE[9:2]` and `bus_aen` is 0 at the rising edge of `bus_iow_n`. Such a write produces exactly one `wr_stb` cycle carrying `wr_sel = bus_addr[1:0]` and the written byte. Within 6 local cycles, the register at that select holds the byte.
- R3: A write with `bus_aen` high, or with a non-matching address, produces no `wr_stb` and leaves every register unchanged.
- R4: `bus_rdata_oe` is high only while the address matches, `bus_aen` is 0 and `bus_ior_n` is 0.
- R5: While `bus_rdata_oe` is high, `bus_rdata` equals the register selected by `bus_addr[1:0]`.
- R6: Each read that hits the port raises `rd_count` by exactly one, within 6 local cycles of `bus_ior_n` rising. The count wraps modulo 2^CNT_W.
- R7: A read with `bus_aen` high or a non-matching address leaves `rd_count` unchanged.
- R8: `wr_stb` is never high for two consecutive local cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running local clock |
| rst | input | 1 | Active-high reset: synchronous in the local domain, asynchronous for the strobe-domain flag |
| bus_addr | input | 10 | Bus I/O address |
| bus_aen | input | 1 | Address-enable; high marks a non-CPU cycle, which is ignored |
| bus_iow_n | input | 1 | Active-low write strobe; its rising edge captures the write |
| bus_ior_n | input | 1 | Active-low read strobe |
| bus_wdata | input | 8 | Write data from the bus |
| bus_rdata | output | 8 | Read data toward the bus |
| bus_rdata_oe | output | 1 | Drive enable for `bus_rdata` |
| wr_stb | output | 1 | One-cycle local write pulse |
| wr_sel | output | 2 | Register select of the delivered write |
| wr_data | output | 8 | Data of the delivered write |
| rd_count | output | 8 | Count of completed port reads |

## Verification
The assertions assume three things about the bus:
- Each strobe stays low for at least four local clock periods.
- Address and enable are held for a cycle on either side of a strobe.
- Consecutive writes are spaced wider than the handshake latency.

The stimulus enforces all three. Each strobe is four cycles wide and opens and closes with a one-cycle hold of address and enable. After every access, the stimulus waits six local cycles before the next one, so each toggle reaches the local side before the flag can flip again.

// File: rtl/isa_io_slave.sv
module isa_io_slave #(
  parameter int ADDR_W = 10,
  parameter int SEL_W  = 2,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter logic [ADDR_W-1:0] BASE = 10'h300
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_aen,
  input  logic              bus_iow_n,
  input  logic              bus_ior_n,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rdata_oe,
  output logic              wr_stb,
  output logic [SEL_W-1:0]  wr_sel,
  output logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  rd_count
);
  localparam int NREG = 1 << SEL_W;

  logic              addr_hit;
  logic              port_hit;
  logic              wr_tog;
  logic [SEL_W-1:0]  cap_sel;
  logic [DATA_W-1:0] cap_data;
  logic [2:0]        tog_s;
  logic [2:0]        ior_s;
  logic              rd_armed;
  logic              rd_release;
  logic [DATA_W-1:0] regs [NREG];

  assign addr_hit = bus_addr[ADDR_W-1:SEL_W] == BASE[ADDR_W-1:SEL_W];
  assign port_hit = addr_hit && !bus_aen;

  always_ff @(posedge bus_iow_n or posedge rst) begin
    if (rst) begin
      wr_tog   <= 1'b0;
      cap_sel  <= '0;
      cap_data <= '0;
    end else if (port_hit) begin
      wr_tog   <= ~wr_tog;
      cap_sel  <= bus_addr[SEL_W-1:0];
      cap_data <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tog_s <= '0;
    else     tog_s <= {tog_s[1:0], wr_tog};
  end

  assign wr_stb  = tog_s[2] ^ tog_s[1];
  assign wr_sel  = cap_sel;
  assign wr_data = cap_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_stb) begin
      regs[cap_sel] <= cap_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ior_s <= '1;
    else     ior_s <= {ior_s[1:0], bus_ior_n};
  end

  assign rd_release = ior_s[1] && !ior_s[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_armed <= 1'b0;
      rd_count <= '0;
    end else if (rd_release) begin
      rd_armed <= 1'b0;
      if (rd_armed) rd_count <= rd_count + 1'b1;
    end else if (!ior_s[1] && port_hit) begin
      rd_armed <= 1'b1;
    end
  end

  assign bus_rdata_oe = port_hit && !bus_ior_n;
  assign bus_rdata    = regs[bus_addr[SEL_W-1:0]];
endmodule

// File: rtl/isa_io_slave_chk.sv
module isa_io_slave_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_aen,
  input logic             bus_ior_n,
  input logic             bus_rdata_oe,
  input logic             wr_stb,
  input logic [CNT_W-1:0] rd_count
);
  p_oe_qualified_r4: assert property (@(posedge clk) disable iff (rst)
    bus_rdata_oe |-> (!bus_aen && !bus_ior_n));

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);

  p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_count != $past(rd_count)) |-> (rd_count == $past(rd_count) + 1'b1));

  p_count_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (!bus_ior_n && $past(!bus_ior_n)) |-> $stable(rd_count));

  always @(posedge clk) begin
    if (rst) begin
      p_reset_clear_r1: assert (!wr_stb);
    end
  end
endmodule

bind isa_io_slave isa_io_slave_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .bus_aen(bus_aen), .bus_ior_n(bus_ior_n),
  .bus_rdata_oe(bus_rdata_oe), .wr_stb(wr_stb), .rd_count(rd_count)
);

// File: tb/tb_isa_io_slave.sv
module tb_isa_io_slave;
  localparam int CLK_P = 10;
  localparam int NVEC  = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] bus_addr = '0;
  logic       bus_aen = 1'b1;
  logic       bus_iow_n = 1'b1;
  logic       bus_ior_n = 1'b1;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       bus_rdata_oe;
  logic       wr_stb;
  logic [1:0] wr_sel;
  logic [7:0] wr_data;
  logic [7:0] rd_count;

  isa_io_slave dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_aen(bus_aen),
    .bus_iow_n(bus_iow_n), .bus_ior_n(bus_ior_n), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe), .wr_stb(wr_stb),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_count(rd_count)
  );

  always #(CLK_P/2) clk = ~clk;

  // {addr[9:0], aen, data[7:0], stores}
  localparam logic [19:0] VEC [NVEC] = '{
    {10'h300, 1'b0, 8'hA5, 1'b1},
    {10'h301, 1'b0, 8'h3C, 1'b1},
    {10'h302, 1'b0, 8'hFF, 1'b1},
    {10'h303, 1'b0, 8'h01, 1'b1},
    {10'h301, 1'b1, 8'h77, 1'b0},
    {10'h305, 1'b0, 8'h88, 1'b0},
    {10'h2FE, 1'b0, 8'h99, 1'b0},
    {10'h303, 1'b0, 8'h80, 1'b1}
  };

  int checks = 0;
  int fails  = 0;
  int stb_cycles = 0;
  logic [1:0] last_sel;
  logic [7:0] last_data;
  logic [7:0] mreg [4];
  logic [7:0] exp_cnt = '0;

  always @(posedge clk) begin
    if (wr_stb) begin
      stb_cycles <= stb_cycles + 1;
      last_sel   <= wr_sel;
      last_data  <= wr_data;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic isa_write(input logic [9:0] a, input logic e, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_aen = e; bus_wdata = d;
    #CLK_P bus_iow_n = 1'b0;
    #(4*CLK_P) bus_iow_n = 1'b1;
    #CLK_P bus_aen = 1'b1; bus_addr = '0;
    repeat (6) @(negedge clk);
  endtask

  task automatic isa_read(input logic [9:0] a, input logic e,
                          output logic [7:0] d, output logic oe);
    @(negedge clk);
    bus_addr = a; bus_aen = e;
    #CLK_P bus_ior_n = 1'b0;
    #(2*CLK_P);
    oe = bus_rdata_oe; d = bus_rdata;
    #(2*CLK_P) bus_ior_n = 1'b1;
    #CLK_P bus_aen = 1'b1; bus_addr = '0;
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(150000*CLK_P);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [7:0] d;
    logic oe;
    int s0;
    for (int i = 0; i < 4; i++) mreg[i] = '0;
    repeat (4) @(negedge clk);
    check("R1 count in reset", rd_count, 0);
    check("R1 stb in reset", wr_stb, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R4 oe idle", bus_rdata_oe, 0);

    for (int i = 0; i < 4; i++) begin
      isa_read(10'h300 | 10'(i), 1'b0, d, oe);
      exp_cnt++;
      check("R1 reg clear", d, 0);
      check("R4 oe on read", oe, 1);
      check("R6 count after read", rd_count, exp_cnt);
    end

    for (int v = 0; v < NVEC; v++) begin
      logic [9:0] a;
      logic e, st;
      logic [7:0] dv;
      {a, e, dv, st} = VEC[v];
      s0 = stb_cycles;
      isa_write(a, e, dv);
      if (st) begin
        mreg[a[1:0]] = dv;
        check("R2 one strobe", stb_cycles - s0, 1);
        check("R2 strobe sel", last_sel, a[1:0]);
        check("R2 strobe data", last_data, dv);
      end else begin
        check("R3 no strobe", stb_cycles - s0, 0);
      end
      for (int k = 0; k < 4; k++) begin
        isa_read(10'h300 | 10'(k), 1'b0, d, oe);
        exp_cnt++;
        check(st ? "R2 reg content" : "R3 reg unchanged", d, mreg[k]);
        check("R5 oe", oe, 1);
      end
      check("R6 count", rd_count, exp_cnt);
    end

    isa_read(10'h310, 1'b0, d, oe);
    check("R4 oe off mismatch", oe, 0);
    check("R7 count mismatch", rd_count, exp_cnt);
    isa_read(10'h302, 1'b1, d, oe);
    check("R4 oe off aen", oe, 0);
    check("R7 count aen", rd_count, exp_cnt);

    while (exp_cnt != 8'hFF) begin
      isa_read(10'h300, 1'b0, d, oe);
      exp_cnt++;
    end
    check("R6 count at max", rd_count, 8'hFF);
    isa_read(10'h301, 1'b0, d, oe);
    exp_cnt++;
    check("R6 count wrap", rd_count, 8'h00);
    check("R5 data during wrap", d, mreg[1]);

    isa_read(10'h300, 1'b0, d, oe);
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 count cleared", rd_count, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    isa_read(10'h303, 1'b0, d, oe);
    check("R1 reg cleared again", d, 0);
    check("R6 count after reset", rd_count, 1);
    finish_up();
  end
endmodule